// File: doc/BRIEF.md
# Key-Protected Flash Command Dispatcher

This block is the command front end of a nonvolatile memory controller. Software writes one 16-bit control word. The upper byte carries an execution key and the low seven bits carry a command code. The dispatcher checks the key, whether it is ready, and the security rules that apply to the code. It then does one of two things. It issues exactly one one-hot command strobe, with the latched target address, to the flash back end. Or it sets a sticky programming-error flag and launches nothing.

A busy input models a higher-priority memory-read port. An accepted command waits while that port is busy and is launched only once it is free. The back end reports completion with a single-cycle done pulse. Until that pulse arrives, the dispatcher is not ready and refuses further commands.

The dispatcher also keeps three pieces of controller state:
- a power-reduction flag;
- a security bit that is requested by a command but only becomes active at the next ordinary reset;
- a one-way chip-erase hard lock.

The requested security bit and the hard lock are held in registers that only the power-on reset clears.

Top module: `nvm_cmd_front`

## Requirements
- R1: A write whose bits 15:8 equal 0xA5 and whose bits 6:0 hold a defined code is accepted. One cycle later, if the memory port is idle, exactly one strobe bit pulses for one cycle, and `cmd_addr` shows the address sampled with the write. Code to strobe bit: 0x02→0, 0x04→1, 0x05→2, 0x06→3, 0x1A→4, 0x1C→5, 0x40→6, 0x41→7, 0x42→8, 0x43→9, 0x44→10, 0x45→11, 0x46→12, 0x7F→13.
- R2: A write with any key other than 0xA5 launches nothing and sets `prog_err`.
- R3: A keyed write that arrives while a command is held or executing is discarded. It sets `prog_err`, and the earlier command still launches with its own strobe.
- R4: `ready` is 1 when idle. It is 0 from the edge that accepts a command until the edge that samples `be_done`.
- R5: While `mem_busy` is 1, an accepted command is held and no strobe appears. The strobe appears one cycle after the first cycle in which `mem_busy` is 0.
- R6: `ctrl_rdata` returns bit 8 = 1 from acceptance until launch and 0 afterwards. Bits 6:0 return the last accepted code, and all other bits are 0.
- R7: Any code not listed in R1 sets `prog_err` and launches nothing.
- R8: Codes 0x05 and 0x06 are rejected with `prog_err` while `sec_active` is 1.
- R9: Launching code 0x45 sets `sec_pending`. `sec_active` takes the value of `sec_pending` only during `rst`, and never changes otherwise.
- R10: Code 0x7F is rejected with `prog_err` unless `sec_active` is 1. Once launched, it sets `hard_lock`, which drives `chip_erase_en` to 0. Only `por` clears `hard_lock`.
- R11: Launching 0x42 sets `power_reduce` and launching 0x43 clears it. `rst` clears it.
- R12: `prog_err` stays set until `err_clr` is 1. A new error in the same cycle as `err_clr` leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high ordinary reset |
| por | input | 1 | Synchronous active-high power-on reset, clears the surviving registers |
| ctrl_wr | input | 1 | Control-word write strobe |
| ctrl_wdata | input | 16 | Control word: key in 15:8, code in 6:0 |
| addr_in | input | ADDR_W | Target address, sampled with the write |
| mem_busy | input | 1 | Higher-priority memory port is busy |
| be_done | input | 1 | Back end completion pulse |
| err_clr | input | 1 | Write-one clear of the error flag |
| ctrl_rdata | output | 16 | Control word readback |
| ready | output | 1 | Dispatcher idle, can take a command |
| prog_err | output | 1 | Sticky programming-error flag |
| cmd_strobe | output | 14 | One-hot command strobe |
| cmd_addr | output | ADDR_W | Address of the launched command |
| sec_pending | output | 1 | Security requested, active after next reset |
| sec_active | output | 1 | Security bit in force |
| hard_lock | output | 1 | Chip-erase hard lock |
| chip_erase_en | output | 1 | Chip erase still permitted |
| power_reduce | output | 1 | Power-reduction mode |

## Verification
The bench targets the case where a second keyed write collides with a held or running command. A design that accepted that write would pulse the strobe of the second command instead of the first. It holds `mem_busy` over several cycles to catch a design that launches while the memory port is busy, and checks that the readback pending bit spans exactly the held interval. It pulses `rst` after the security request and again after the hard lock, to expose a design that activates security at once or lets the ordinary reset clear the lock. It also raises an error and its clear in the same cycle to expose a design where the clear wins.

// File: rtl/nvm_cmd_pkg.sv
package nvm_cmd_pkg;

    localparam int unsigned CODE_W   = 7;
    localparam int unsigned KEY_W    = 8;
    localparam int unsigned N_OPS    = 14;
    localparam int unsigned OP_W     = $clog2(N_OPS);
    localparam logic [KEY_W-1:0] CTRL_KEY = 8'hA5;

    typedef enum logic [OP_W-1:0] {
        OP_ROW_ERASE  = 4'd0,
        OP_PAGE_WRITE = 4'd1,
        OP_CFG_ERASE  = 4'd2,
        OP_CFG_WRITE  = 4'd3,
        OP_DF_ERASE   = 4'd4,
        OP_DF_WRITE   = 4'd5,
        OP_LOCK       = 4'd6,
        OP_UNLOCK     = 4'd7,
        OP_PWR_ON     = 4'd8,
        OP_PWR_OFF    = 4'd9,
        OP_BUF_CLEAR  = 4'd10,
        OP_SEC_SET    = 4'd11,
        OP_CACHE_INV  = 4'd12,
        OP_HARD_LOCK  = 4'd13
    } op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HOLD = 2'd1,
        ST_RUN  = 2'd2
    } seq_e;

    typedef struct packed {
        logic known;
        op_e  op;
    } dec_t;

    function automatic dec_t decode_code(input logic [CODE_W-1:0] code);
        dec_t d;
        d.known = 1'b1;
        d.op    = OP_ROW_ERASE;
        case (code)
            7'h02:   d.op = OP_ROW_ERASE;
            7'h04:   d.op = OP_PAGE_WRITE;
            7'h05:   d.op = OP_CFG_ERASE;
            7'h06:   d.op = OP_CFG_WRITE;
            7'h1A:   d.op = OP_DF_ERASE;
            7'h1C:   d.op = OP_DF_WRITE;
            7'h40:   d.op = OP_LOCK;
            7'h41:   d.op = OP_UNLOCK;
            7'h42:   d.op = OP_PWR_ON;
            7'h43:   d.op = OP_PWR_OFF;
            7'h44:   d.op = OP_BUF_CLEAR;
            7'h45:   d.op = OP_SEC_SET;
            7'h46:   d.op = OP_CACHE_INV;
            7'h7F:   d.op = OP_HARD_LOCK;
            default: d.known = 1'b0;
        endcase
        return d;
    endfunction

    function automatic logic needs_open(input op_e op);
        return (op == OP_CFG_ERASE) || (op == OP_CFG_WRITE);
    endfunction

    function automatic logic needs_secure(input op_e op);
        return op == OP_HARD_LOCK;
    endfunction

endpackage

// File: rtl/nvm_cmd_check.sv
module nvm_cmd_check
    import nvm_cmd_pkg::*;
(
    input  logic                       wr,
    input  logic [KEY_W+CODE_W:0]      wdata,
    input  logic                       ready,
    input  logic                       sec_active,
    output logic                       accept,
    output logic                       reject,
    output op_e                        op
);
    localparam int unsigned KEY_LSB = CODE_W + 1;

    logic key_ok;
    logic gated;
    dec_t dec;

    always_comb begin
        key_ok = (wdata[KEY_LSB +: KEY_W] == CTRL_KEY);
        dec    = decode_code(wdata[CODE_W-1:0]);
        gated  = (needs_open(dec.op) && sec_active) ||
                 (needs_secure(dec.op) && !sec_active);
        op     = dec.op;
        accept = wr && key_ok && ready && dec.known && !gated;
        reject = wr && !(key_ok && ready && dec.known && !gated);
    end
endmodule

// File: rtl/nvm_cmd_seq.sv
module nvm_cmd_seq
    import nvm_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept,
    input  logic              reject,
    input  op_e               op_in,
    input  logic [CODE_W-1:0] code_in,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mem_busy,
    input  logic              be_done,
    input  logic              err_clr,
    output logic              ready,
    output logic [N_OPS-1:0]  strobe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              pend,
    output logic              prog_err,
    output logic [CODE_W-1:0] last_code,
    output logic              launch,
    output op_e               launch_op
);
    seq_e              state;
    op_e               op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [N_OPS-1:0]  strobe_nxt;

    assign ready     = (state == ST_IDLE);
    assign launch    = (state == ST_HOLD) && !mem_busy;
    assign launch_op = op_q;
    assign cmd_addr  = addr_q;

    generate
        for (genvar i = 0; i < N_OPS; i++) begin : g_strobe
            assign strobe_nxt[i] = launch && (op_q == op_e'(i));
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (accept)    state <= ST_HOLD;
                ST_HOLD: if (!mem_busy) state <= ST_RUN;
                ST_RUN:  if (be_done)   state <= ST_IDLE;
                default:                state <= ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q      <= OP_ROW_ERASE;
            addr_q    <= '0;
            last_code <= '0;
        end else if (accept) begin
            op_q      <= op_in;
            addr_q    <= addr_in;
            last_code <= code_in;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend     <= 1'b0;
            strobe   <= '0;
            prog_err <= 1'b0;
        end else begin
            strobe <= strobe_nxt;
            if (accept)      pend <= 1'b1;
            else if (launch) pend <= 1'b0;
            if (reject)       prog_err <= 1'b1;
            else if (err_clr) prog_err <= 1'b0;
        end
    end

    assert_strobe_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0(strobe));
    assert_busy_not_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |-> !ready);
    assert_launch_bus_idle_R5: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |-> !$past(mem_busy));
    assert_pend_done_at_launch_R6: assert property (@(posedge clk) disable iff (rst)
        (|strobe) |-> !pend);
    assert_err_sticky_R12: assert property (@(posedge clk) disable iff (rst)
        (prog_err && !err_clr) |=> prog_err);
endmodule

// File: rtl/nvm_sec_state.sv
module nvm_sec_state
    import nvm_cmd_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic por,
    input  logic launch,
    input  op_e  launch_op,
    output logic sec_pending,
    output logic sec_active,
    output logic hard_lock,
    output logic power_reduce
);
    logic fire;
    assign fire = launch && !rst && !por;

    // Registers that only the power-on reset clears.
    always_ff @(posedge clk) begin
        if (por) begin
            sec_pending <= 1'b0;
            hard_lock   <= 1'b0;
        end else if (fire) begin
            if (launch_op == OP_SEC_SET)   sec_pending <= 1'b1;
            if (launch_op == OP_HARD_LOCK) hard_lock   <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (por)      sec_active <= 1'b0;
        else if (rst) sec_active <= sec_pending;
    end

    always_ff @(posedge clk) begin
        if (por || rst) begin
            power_reduce <= 1'b0;
        end else if (fire) begin
            if (launch_op == OP_PWR_ON)       power_reduce <= 1'b1;
            else if (launch_op == OP_PWR_OFF) power_reduce <= 1'b0;
        end
    end

    assert_sec_only_on_reset_R9: assert property (@(posedge clk) disable iff (rst || por)
        (!$past(rst) && !$past(por)) |-> $stable(sec_active));
    assert_lock_one_way_R10: assert property (@(posedge clk) disable iff (por)
        (!$past(por) && $past(hard_lock)) |-> hard_lock);
endmodule

// File: rtl/nvm_cmd_front.sv
module nvm_cmd_front
    import nvm_cmd_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              por,
    input  logic              ctrl_wr,
    input  logic [15:0]       ctrl_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic              mem_busy,
    input  logic              be_done,
    input  logic              err_clr,
    output logic [15:0]       ctrl_rdata,
    output logic              ready,
    output logic              prog_err,
    output logic [N_OPS-1:0]  cmd_strobe,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              sec_pending,
    output logic              sec_active,
    output logic              hard_lock,
    output logic              chip_erase_en,
    output logic              power_reduce
);
    logic              seq_rst;
    logic              accept;
    logic              reject;
    op_e               dec_op;
    logic              pend;
    logic [CODE_W-1:0] last_code;
    logic              launch;
    op_e               launch_op;

    assign seq_rst = rst || por;

    nvm_cmd_check u_check (
        .wr         (ctrl_wr),
        .wdata      (ctrl_wdata),
        .ready      (ready),
        .sec_active (sec_active),
        .accept     (accept),
        .reject     (reject),
        .op         (dec_op)
    );

    nvm_cmd_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk       (clk),
        .rst       (seq_rst),
        .accept    (accept),
        .reject    (reject),
        .op_in     (dec_op),
        .code_in   (ctrl_wdata[CODE_W-1:0]),
        .addr_in   (addr_in),
        .mem_busy  (mem_busy),
        .be_done   (be_done),
        .err_clr   (err_clr),
        .ready     (ready),
        .strobe    (cmd_strobe),
        .cmd_addr  (cmd_addr),
        .pend      (pend),
        .prog_err  (prog_err),
        .last_code (last_code),
        .launch    (launch),
        .launch_op (launch_op)
    );

    nvm_sec_state u_sec (
        .clk          (clk),
        .rst          (rst),
        .por          (por),
        .launch       (launch),
        .launch_op    (launch_op),
        .sec_pending  (sec_pending),
        .sec_active   (sec_active),
        .hard_lock    (hard_lock),
        .power_reduce (power_reduce)
    );

    assign chip_erase_en = !hard_lock;
    assign ctrl_rdata    = {7'b0, pend, 1'b0, last_code};

    assert_bad_key_no_start_R2: assert property (@(posedge clk) disable iff (seq_rst)
        (ctrl_wr && ctrl_wdata[15:8] != CTRL_KEY && ready) |=> (ready && prog_err));
    assert_gated_cfg_R8: assert property (@(posedge clk) disable iff (seq_rst)
        (ctrl_wr && sec_active && ready &&
         (ctrl_wdata[6:0] == 7'h05 || ctrl_wdata[6:0] == 7'h06)) |=> ready);
endmodule

// File: tb/nvm_cmd_front_bench.sv
module nvm_cmd_front_bench;
    localparam int ADDR_W = 18;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              por = 1'b1;
    logic              ctrl_wr = 1'b0;
    logic [15:0]       ctrl_wdata = '0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic              mem_busy = 1'b0;
    logic              be_done = 1'b0;
    logic              err_clr = 1'b0;
    logic [15:0]       ctrl_rdata;
    logic              ready, prog_err;
    logic [13:0]       cmd_strobe;
    logic [ADDR_W-1:0] cmd_addr;
    logic              sec_pending, sec_active, hard_lock, chip_erase_en, power_reduce;

    int total = 0;
    int fails = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    nvm_cmd_front #(.ADDR_W(ADDR_W)) u_nvm_cmd_front (
        .clk(clk), .rst(rst), .por(por), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata),
        .addr_in(addr_in), .mem_busy(mem_busy), .be_done(be_done), .err_clr(err_clr),
        .ctrl_rdata(ctrl_rdata), .ready(ready), .prog_err(prog_err),
        .cmd_strobe(cmd_strobe), .cmd_addr(cmd_addr), .sec_pending(sec_pending),
        .sec_active(sec_active), .hard_lock(hard_lock), .chip_erase_en(chip_erase_en),
        .power_reduce(power_reduce)
    );

    // {key, code, accepted, strobe bit}
    localparam logic [19:0] VEC [16] = '{
        {8'hA5, 7'h02, 1'b1, 4'd0},  {8'hA5, 7'h04, 1'b1, 4'd1},
        {8'hA5, 7'h05, 1'b1, 4'd2},  {8'hA5, 7'h06, 1'b1, 4'd3},
        {8'hA5, 7'h1A, 1'b1, 4'd4},  {8'hA5, 7'h1C, 1'b1, 4'd5},
        {8'hA5, 7'h40, 1'b1, 4'd6},  {8'hA5, 7'h41, 1'b1, 4'd7},
        {8'hA5, 7'h44, 1'b1, 4'd10}, {8'hA5, 7'h46, 1'b1, 4'd12},
        {8'hA5, 7'h03, 1'b0, 4'd0},  {8'hA5, 7'h00, 1'b0, 4'd0},
        {8'hA5, 7'h7E, 1'b0, 4'd0},  {8'h5A, 7'h02, 1'b0, 4'd0},
        {8'hA4, 7'h04, 1'b0, 4'd0},  {8'hA5, 7'h7F, 1'b0, 4'd0}
    };

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] k, input logic [6:0] c,
                           input logic [ADDR_W-1:0] a);
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = {k, 1'b0, c}; addr_in = a;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    // Called at the negedge after the accepting edge, memory port idle.
    task automatic finish_cmd(input int idx, input logic [ADDR_W-1:0] a, input string tag);
        chk(ready == 1'b0, {tag, "/R4 ready low"}, 32'(ready), 0);
        @(negedge clk);
        chk(cmd_strobe == (14'd1 << idx), {tag, " strobe"}, 32'(cmd_strobe), 32'(14'd1 << idx));
        chk(cmd_addr == a, {tag, " addr"}, 32'(cmd_addr), 32'(a));
        chk(ctrl_rdata[8] == 1'b0, {tag, "/R6 pending cleared"}, 32'(ctrl_rdata[8]), 0);
        be_done = 1'b1;
        @(negedge clk);
        be_done = 1'b0;
        chk(ready == 1'b1, {tag, "/R4 ready back"}, 32'(ready), 1);
    endtask

    task automatic clear_err;
        @(negedge clk); err_clr = 1'b1;
        @(negedge clk); err_clr = 1'b0;
        chk(prog_err == 1'b0, "R12 clear", 32'(prog_err), 0);
    endtask

    task automatic pulse_rst;
        @(negedge clk); rst = 1'b1;
        @(negedge clk); rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++; fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0; por = 1'b0;
        @(negedge clk);
        chk(ready == 1'b1, "reset ready R4", 32'(ready), 1);
        chk(prog_err == 1'b0, "reset err R12", 32'(prog_err), 0);
        chk(cmd_strobe == '0, "reset strobe R1", 32'(cmd_strobe), 0);
        chk(ctrl_rdata == '0, "reset readback R6", 32'(ctrl_rdata), 0);
        chk({sec_pending, sec_active, hard_lock, chip_erase_en, power_reduce} == 5'b00010,
            "reset security R10", 32'({sec_pending, sec_active, hard_lock, chip_erase_en, power_reduce}), 32'h2);

        // Table walk
        for (int i = 0; i < 16; i++) begin
            logic [7:0] k;
            logic [6:0] c;
            logic       acc;
            int         idx;
            logic [ADDR_W-1:0] a;
            string      tag;
            k = VEC[i][19:12]; c = VEC[i][11:5]; acc = VEC[i][4]; idx = int'(VEC[i][3:0]);
            a = ADDR_W'(18'h100 + i * 18'h41);
            tag = acc ? "R1" : (k != 8'hA5 ? "R2" : (c == 7'h7F ? "R10" : "R7"));
            wr_ctrl(k, c, a);
            if (acc) begin
                chk(ctrl_rdata[8] == 1'b1, "R6 pending set", 32'(ctrl_rdata[8]), 1);
                chk(ctrl_rdata[6:0] == c, "R6 code readback", 32'(ctrl_rdata[6:0]), 32'(c));
                finish_cmd(idx, a, tag);
            end else begin
                chk(prog_err == 1'b1, {tag, " error set"}, 32'(prog_err), 1);
                chk(ready == 1'b1, {tag, " stays ready"}, 32'(ready), 1);
                @(negedge clk);
                chk(cmd_strobe == '0, {tag, " no strobe"}, 32'(cmd_strobe), 0);
                clear_err();
            end
        end

        // R5 hold under memory busy, R3 collision while held
        mem_busy = 1'b1;
        wr_ctrl(8'hA5, 7'h02, 18'h2AA);
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(cmd_strobe == '0, "R5 held no strobe", 32'(cmd_strobe), 0);
            chk(ctrl_rdata[8] == 1'b1, "R6 pending while held", 32'(ctrl_rdata[8]), 1);
        end
        wr_ctrl(8'hA5, 7'h04, 18'h3FF);
        chk(prog_err == 1'b1, "R3 collision while held", 32'(prog_err), 1);
        mem_busy = 1'b0;
        finish_cmd(0, 18'h2AA, "R5/R3 first cmd launches");
        clear_err();

        // R3 collision while executing
        wr_ctrl(8'hA5, 7'h04, 18'h011);
        @(negedge clk);
        chk(cmd_strobe == 14'd2, "R3 run strobe", 32'(cmd_strobe), 2);
        wr_ctrl(8'hA5, 7'h06, 18'h022);
        chk(prog_err == 1'b1, "R3 collision while running", 32'(prog_err), 1);
        chk(cmd_strobe == '0, "R3 no second strobe", 32'(cmd_strobe), 0);
        be_done = 1'b1; @(negedge clk); be_done = 1'b0;
        chk(ready == 1'b1, "R3 ready after done", 32'(ready), 1);
        chk(cmd_addr == 18'h011, "R3 addr kept", 32'(cmd_addr), 32'h11);
        clear_err();

        // R11 power reduction
        wr_ctrl(8'hA5, 7'h42, 18'h0); finish_cmd(8, 18'h0, "R11 set");
        chk(power_reduce == 1'b1, "R11 set", 32'(power_reduce), 1);
        wr_ctrl(8'hA5, 7'h43, 18'h0); finish_cmd(9, 18'h0, "R11 clear");
        chk(power_reduce == 1'b0, "R11 clear", 32'(power_reduce), 0);
        wr_ctrl(8'hA5, 7'h42, 18'h0); finish_cmd(8, 18'h0, "R11 set again");
        pulse_rst();
        chk(power_reduce == 1'b0, "R11 reset clears", 32'(power_reduce), 0);

        // R9 security request takes effect only at reset
        wr_ctrl(8'hA5, 7'h45, 18'h0); finish_cmd(11, 18'h0, "R9 sec set");
        chk(sec_pending == 1'b1, "R9 pending", 32'(sec_pending), 1);
        chk(sec_active == 1'b0, "R9 not active yet", 32'(sec_active), 0);
        pulse_rst();
        chk(sec_active == 1'b1, "R9 active after reset", 32'(sec_active), 1);

        // R8 config commands gated by security
        wr_ctrl(8'hA5, 7'h05, 18'h0);
        chk(prog_err == 1'b1 && ready == 1'b1, "R8 cfg erase rejected", 32'({prog_err, ready}), 3);
        @(negedge clk);
        chk(cmd_strobe == '0, "R8 no strobe", 32'(cmd_strobe), 0);
        clear_err();
        wr_ctrl(8'hA5, 7'h06, 18'h0);
        chk(prog_err == 1'b1 && ready == 1'b1, "R8 cfg write rejected", 32'({prog_err, ready}), 3);
        clear_err();

        // R10 hard lock
        wr_ctrl(8'hA5, 7'h7F, 18'h0); finish_cmd(13, 18'h0, "R10 hard lock");
        chk(hard_lock == 1'b1 && chip_erase_en == 1'b0, "R10 lock set",
            32'({hard_lock, chip_erase_en}), 2);
        pulse_rst();
        chk(hard_lock == 1'b1, "R10 survives reset", 32'(hard_lock), 1);
        chk(sec_active == 1'b1, "R9 survives reset", 32'(sec_active), 1);

        // R12 set wins over clear
        @(negedge clk);
        ctrl_wr = 1'b1; ctrl_wdata = 16'h3302; err_clr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0; err_clr = 1'b0;
        chk(prog_err == 1'b1, "R12 set wins", 32'(prog_err), 1);
        @(negedge clk);
        chk(prog_err == 1'b1, "R12 sticky", 32'(prog_err), 1);
        clear_err();

        // Power-on reset clears surviving state
        @(negedge clk); por = 1'b1; rst = 1'b1;
        @(negedge clk); por = 1'b0; rst = 1'b0;
        chk({sec_pending, sec_active, hard_lock, chip_erase_en} == 4'b0001,
            "R10 por clears", 32'({sec_pending, sec_active, hard_lock, chip_erase_en}), 1);

        finished = 1;
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule